// File: doc/BRIEF.md
# Per-Byte Data Bus Parity Unit

This block covers one parity lane per byte of a 64-bit data bus. When the bus is carrying a write, it computes one even-parity bit for each data byte. It presents those bits on its parity outputs together with an output enable that marks the write. When a read-type transfer is on the bus, it compares the parity bits received from the system with the received data. It then reports any mismatch on an active-low check output.

The cycle type selects which bytes take part in the comparison. On ordinary code, memory and I/O reads, only the bytes whose active-low byte enables are asserted are checked. On a cache line fill, all eight bytes are checked whatever the byte enables say. Interrupt acknowledge cycles arrive in pairs. An internal phase bit tells the two apart, and only the second one of each pair is checked. The comparison is made in the clock where the data-valid strobe is high. Its result appears on the check output one clock later and stays there for that one clock.

Top module: `dpar_unit`

## Requirements
- R1: While `cyc_type` is 5 (write), `par_oe` is 1 and `par_out[n]` equals the XOR of `bus_data[8n+7:8n]` for n = 0..7, so that each byte plus its parity bit has an even number of ones. The outputs follow the inputs combinationally.
- R2: While `cyc_type` is anything other than 5, `par_oe` is 0 and `par_out` is all zeros.
- R3: A transfer is strobed when `data_valid` is 1 at a rising edge. If a strobed code read (1), memory read (2) or I/O read (3) has an enabled byte whose `par_in` bit differs from that byte's even parity, `chk_n` is 0 in the next clock.
- R4: Outside line fills, a byte whose `be_n` bit is 1 is ignored. A parity error on such a byte alone leaves `chk_n` at 1 in the next clock.
- R5: On a strobed line fill (`cyc_type` 6), all eight bytes are checked regardless of `be_n`. Any byte's mismatch drives `chk_n` to 0 in the next clock.
- R6: Strobed interrupt acknowledge transfers (`cyc_type` 4) alternate between first and second, starting with first after reset. A first one is never checked. A second one is checked on its enabled bytes, like a read.
- R7: Writes (5), idle codes (0 and 7) and clocks where `data_valid` is 0 never drive `chk_n` low in the next clock.
- R8: `rst` is synchronous and active high. It forces `chk_n` to 1 in the next clock and returns the acknowledge phase to first.
- R9: `chk_n` is low for exactly one clock per failing transfer. It returns to 1 in the clock after any clock that has no failing strobed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 64 | Data on the bus (write data or received read data) |
| par_in | input | 8 | Parity bits received from the system, bit n for byte n |
| be_n | input | 8 | Active-low byte enables, bit n for byte n |
| cyc_type | input | 3 | 0 idle, 1 code read, 2 memory read, 3 I/O read, 4 interrupt acknowledge, 5 write, 6 line fill, 7 idle |
| data_valid | input | 1 | Marks the clock in which read data is valid |
| par_out | output | 8 | Generated even parity per byte, zero when not writing |
| par_oe | output | 1 | High while parity is driven (write cycle) |
| chk_n | output | 1 | Active-low parity error flag, one clock after the failing transfer |

## Verification
The bench puts an error on a disabled byte during a memory read. A design that ignored the enables would flag it. It repeats the same error during a line fill, where a design that applied the enables would miss it. It runs acknowledge pairs with bad parity on both halves, and then resets while the phase is on second. A design whose phase tracking is wrong either flags the first half or skips the second half after the reset. Random traffic with back-to-back failures and writes that carry bad `par_in` checks two more things. The check output must drop for one clock only, and a write must never raise it.

// File: rtl/dpar_pkg.sv
package dpar_pkg;

    localparam int DATA_W = 64;
    localparam int BYTE_W = 8;
    localparam int LANES  = DATA_W / BYTE_W;

    typedef enum logic [2:0] {
        CYC_IDLE    = 3'd0,
        CYC_CODE_RD = 3'd1,
        CYC_MEM_RD  = 3'd2,
        CYC_IO_RD   = 3'd3,
        CYC_INTA    = 3'd4,
        CYC_WRITE   = 3'd5,
        CYC_FILL    = 3'd6,
        CYC_IDLE2   = 3'd7
    } cyc_e;

    typedef struct packed {
        logic checked;   // read-type transfer that may be checked
        logic all_lanes; // ignore byte enables
        logic is_inta;   // subject to acknowledge pairing
        logic drives;    // write: parity driven
    } cyc_class_t;

    function automatic cyc_class_t classify(input logic [2:0] code);
        cyc_class_t c;
        c = '0;
        case (code)
            CYC_CODE_RD, CYC_MEM_RD, CYC_IO_RD: c.checked = 1'b1;
            CYC_INTA: begin
                c.checked = 1'b1;
                c.is_inta = 1'b1;
            end
            CYC_FILL: begin
                c.checked   = 1'b1;
                c.all_lanes = 1'b1;
            end
            CYC_WRITE: c.drives = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic [LANES-1:0] lane_parity(input logic [DATA_W-1:0] d);
        logic [LANES-1:0] p;
        for (int n = 0; n < LANES; n++) p[n] = ^d[n*BYTE_W +: BYTE_W];
        return p;
    endfunction

endpackage

// File: rtl/dpar_lane_gen.sv
module dpar_lane_gen #(
    parameter int DATA_W = dpar_pkg::DATA_W,
    parameter int BYTE_W = dpar_pkg::BYTE_W,
    localparam int LANES = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [LANES-1:0]  parity
);
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        assign parity[n] = ^data[n*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/dpar_inta_phase.sv
module dpar_inta_phase (
    input  logic clk,
    input  logic rst,
    input  logic ack_strobe,
    output logic second
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst)             phase_q <= 1'b0;
        else if (ack_strobe) phase_q <= ~phase_q;
    end

    assign second = phase_q;
endmodule

// File: rtl/dpar_check_mask.sv
module dpar_check_mask #(
    parameter int LANES = dpar_pkg::LANES
) (
    input  dpar_pkg::cyc_class_t cls,
    input  logic                 strobe,
    input  logic                 ack_second,
    input  logic [LANES-1:0]     be_n,
    output logic [LANES-1:0]     mask
);
    logic enable;

    always_comb begin
        enable = strobe && cls.checked && (!cls.is_inta || ack_second);
        if (!enable)           mask = '0;
        else if (cls.all_lanes) mask = '1;
        else                   mask = ~be_n;
    end
endmodule

// File: rtl/dpar_unit.sv
module dpar_unit #(
    parameter int DATA_W = dpar_pkg::DATA_W,
    parameter int BYTE_W = dpar_pkg::BYTE_W,
    localparam int LANES = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [LANES-1:0]  par_in,
    input  logic [LANES-1:0]  be_n,
    input  logic [2:0]        cyc_type,
    input  logic              data_valid,
    output logic [LANES-1:0]  par_out,
    output logic              par_oe,
    output logic              chk_n
);
    import dpar_pkg::*;

    cyc_class_t       cls;
    logic [LANES-1:0] gen_par;
    logic [LANES-1:0] mask;
    logic             ack_second;
    logic             err_q;

    assign cls = classify(cyc_type);

    dpar_lane_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_gen (
        .data   (bus_data),
        .parity (gen_par)
    );

    dpar_inta_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .ack_strobe (data_valid && cls.is_inta),
        .second     (ack_second)
    );

    dpar_check_mask #(.LANES(LANES)) u_mask (
        .cls        (cls),
        .strobe     (data_valid),
        .ack_second (ack_second),
        .be_n       (be_n),
        .mask       (mask)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= |((par_in ^ gen_par) & mask);
    end

    assign par_oe  = cls.drives;
    assign par_out = cls.drives ? gen_par : '0;
    assign chk_n   = ~err_q;
endmodule

// File: rtl/dpar_checker.sv
module dpar_checker #(
    parameter int DATA_W = dpar_pkg::DATA_W,
    parameter int BYTE_W = dpar_pkg::BYTE_W,
    localparam int LANES = DATA_W / BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] bus_data,
    input logic [LANES-1:0]  par_in,
    input logic [LANES-1:0]  be_n,
    input logic [2:0]        cyc_type,
    input logic              data_valid,
    input logic [LANES-1:0]  par_out,
    input logic              par_oe,
    input logic              chk_n
);
    function automatic logic lanes_even(input logic [DATA_W-1:0] d, input logic [LANES-1:0] p);
        logic ok;
        ok = 1'b1;
        for (int n = 0; n < LANES; n++)
            if ((^d[n*BYTE_W +: BYTE_W]) ^ p[n]) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [LANES-1:0] bad_lanes(input logic [DATA_W-1:0] d, input logic [LANES-1:0] p);
        logic [LANES-1:0] b;
        for (int n = 0; n < LANES; n++) b[n] = (^d[n*BYTE_W +: BYTE_W]) ^ p[n];
        return b;
    endfunction

    AST_WRITE_EVEN: assert property (@(posedge clk) disable iff (rst)
        par_oe |-> lanes_even(bus_data, par_out)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !par_oe |-> (par_out == '0)); // R2

    AST_READ_FLAG: assert property (@(posedge clk) disable iff (rst)
        (data_valid && cyc_type inside {3'd1, 3'd2, 3'd3} &&
         ((bad_lanes(bus_data, par_in) & ~be_n) != '0)) |=> !chk_n); // R3

    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (data_valid && cyc_type inside {3'd1, 3'd2, 3'd3} &&
         ((bad_lanes(bus_data, par_in) & ~be_n) == '0)) |=> chk_n); // R4

    AST_FILL_ALL: assert property (@(posedge clk) disable iff (rst)
        (data_valid && cyc_type == 3'd6 && (bad_lanes(bus_data, par_in) != '0)) |=> !chk_n); // R5

    AST_NO_FLAG_NONREAD: assert property (@(posedge clk) disable iff (rst)
        (!data_valid || cyc_type inside {3'd0, 3'd5, 3'd7}) |=> chk_n); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> chk_n); // R8
endmodule

bind dpar_unit dpar_checker #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst(rst), .bus_data(bus_data), .par_in(par_in), .be_n(be_n),
    .cyc_type(cyc_type), .data_valid(data_valid), .par_out(par_out),
    .par_oe(par_oe), .chk_n(chk_n)
);

// File: tb/dpar_unit_test.sv
`timescale 1ns/1ps
module dpar_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] bus_data = '0;
    logic [7:0]  par_in = '0;
    logic [7:0]  be_n = '1;
    logic [2:0]  cyc_type = '0;
    logic        data_valid = 1'b0;
    logic [7:0]  par_out;
    logic        par_oe;
    logic        chk_n;

    int checks = 0;
    int errors = 0;
    logic  exp_chk_n = 1'b1;
    logic  m_second = 1'b0;
    string exp_tag = "R8";
    bit    done = 0;

    always #2.5 clk = ~clk;

    dpar_unit uut (
        .clk(clk), .rst(rst), .bus_data(bus_data), .par_in(par_in), .be_n(be_n),
        .cyc_type(cyc_type), .data_valid(data_valid), .par_out(par_out),
        .par_oe(par_oe), .chk_n(chk_n)
    );

    function automatic logic [7:0] even_bits(input logic [63:0] d);
        logic [7:0] p;
        for (int n = 0; n < 8; n++) begin
            p[n] = 1'b0;
            for (int b = 0; b < 8; b++) p[n] = p[n] ^ d[8*n + b];
        end
        return p;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a negedge: checks the flag from the previous transfer, drives a new one.
    task automatic xfer(input logic [2:0] c, input logic [63:0] d, input logic [7:0] p,
                        input logic [7:0] be, input logic dv);
        logic [7:0] mask;
        logic       chk;
        string      tag;
        check(exp_tag, {63'd0, chk_n}, {63'd0, exp_chk_n});
        cyc_type = c; bus_data = d; par_in = p; be_n = be; data_valid = dv;
        #1;
        if (c == 3'd5) begin
            check("R1", {55'd0, par_oe, par_out}, {55'd0, 1'b1, even_bits(d)});
        end else begin
            check("R2", {55'd0, par_oe, par_out}, 64'd0);
        end
        chk = 1'b0; mask = 8'h00; tag = "R7";
        if (dv) begin
            case (c)
                3'd1, 3'd2, 3'd3: begin chk = 1'b1; mask = ~be; tag = "R3"; end
                3'd6: begin chk = 1'b1; mask = 8'hFF; tag = "R5"; end
                3'd4: begin
                    chk = m_second; mask = ~be; tag = "R6";
                    m_second = ~m_second;
                end
                default: ;
            endcase
        end
        exp_chk_n = !(chk && (((p ^ even_bits(d)) & mask) != 8'h00));
        if (tag == "R3" && exp_chk_n && ((p ^ even_bits(d)) != 8'h00)) tag = "R4";
        if (tag == "R3" && exp_chk_n) tag = "R9";
        exp_tag = tag;
        @(negedge clk);
    endtask

    task automatic do_reset();
        check(exp_tag, {63'd0, chk_n}, {63'd0, exp_chk_n});
        rst = 1'b1; data_valid = 1'b1; cyc_type = 3'd2; par_in = ~even_bits(bus_data); be_n = 8'h00;
        @(negedge clk);
        rst = 1'b0; data_valid = 1'b0;
        m_second = 1'b0; exp_chk_n = 1'b1; exp_tag = "R8";
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        check("R8", {63'd0, chk_n}, 64'd1);
        rst = 1'b0;
        d = 64'h0123_4567_89AB_CDEF;
        // R1: write with wrong par_in must not flag (R7)
        xfer(3'd5, d, ~even_bits(d), 8'h00, 1'b1);
        // R3: enabled byte 2 bad on memory read
        xfer(3'd2, d, even_bits(d) ^ 8'h04, 8'h00, 1'b1);
        // R9: a good read right after drops the flag again
        xfer(3'd1, d, even_bits(d), 8'h00, 1'b1);
        // R4: byte 5 bad but disabled
        xfer(3'd3, d, even_bits(d) ^ 8'h20, 8'h20, 1'b1);
        // R5: same error on a line fill is caught
        xfer(3'd6, d, even_bits(d) ^ 8'h20, 8'h20, 1'b1);
        // R7: bad parity with data_valid low
        xfer(3'd2, d, ~even_bits(d), 8'h00, 1'b0);
        // R6: first acknowledge unchecked, second checked
        xfer(3'd4, d, ~even_bits(d), 8'h00, 1'b1);
        xfer(3'd4, d, ~even_bits(d), 8'h00, 1'b1);
        // R8: reset while phase is on second
        xfer(3'd4, d, even_bits(d), 8'h00, 1'b1);
        do_reset();
        xfer(3'd4, d, ~even_bits(d), 8'h00, 1'b1);  // R6: first again after reset
        xfer(3'd4, d, ~even_bits(d), 8'h00, 1'b1);
        // R9: back-to-back failing reads
        xfer(3'd2, d, ~even_bits(d), 8'h00, 1'b1);
        xfer(3'd2, d, ~even_bits(d), 8'h00, 1'b1);
        xfer(3'd0, d, ~even_bits(d), 8'h00, 1'b1);
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] flip;
            d = {$urandom, $urandom};
            flip = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom);
            xfer(3'($urandom_range(0, 7)), d, even_bits(d) ^ flip, 8'($urandom),
                 $urandom_range(0, 4) != 0);
        end
        check(exp_tag, {63'd0, chk_n}, {63'd0, exp_chk_n});
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule